// File: doc/BRIEF.md
# Infrared Pulse-Width Symbol Capture

This block watches the output of an infrared receiver, whose line idles high and pulls low while a carrier burst is present, and turns the waveform into raw duration symbols. A symbol opens on a high-to-low transition. It records how long the line stayed low and then how long it stayed high, until the next high-to-low transition starts the following symbol. A protocol decoder further along reads these symbols from a FIFO that takes them over a one-cycle valid strobe.

The time base comes from the system clock. A frequency field, set to the clock rate in MHz minus one, drives a prescaler that produces a microsecond tick. A fixed number of microsecond ticks makes one duration unit, which is 10 µs by default. When a symbol's low and high durations together reach a programmable maximum, the block closes the stream. It emits the pending symbol flagged as the stream end and raises a timeout event. A maximum of 16000 units (160 ms) is the recommended setting.

The receiver input passes through a synchroniser and a glitch filter before it is measured. Capture is armed by an enable level together with a start strobe. Dropping the enable throws away any symbol still being measured.

Top module: `ir_symbol_capture`

## Requirements
- R1: The prescaler gives one microsecond tick every `freq_mhz_m1`+1 clock cycles, and one duration unit every UNIT_US microsecond ticks (default 10). The measured durations therefore scale with the frequency field.
- R2: A symbol starts at a filtered high-to-low transition. `sym_data` carries the low duration in bits [DUR_W-1:0] and the following high duration in bits [2*DUR_W-1:DUR_W], both in units (DUR_W=16 gives bits [15:0] and [31:16]).
- R3: When a high phase is ended by a new high-to-low transition, the symbol is emitted with `sym_end`=0 and measurement of the next symbol begins at once.
- R4: When low duration plus high duration reaches `max_width` during the high phase, the symbol is emitted with `sym_end`=1, and `timeout_evt` pulses in the same cycle. The two emitted durations then sum exactly to `max_width`.
- R5: After a stream end the engine waits for the next high-to-low transition. A line that stays high produces no further symbols.
- R6: A change of the input level that lasts less than one duration unit is ignored and does not split or start a symbol.
- R7: Both duration fields saturate at their all-ones value and never wrap.
- R8: No symbol is produced until `enable` is high and a `start` strobe has arrived while it is high.
- R9: Clearing `enable` returns the engine to idle at once and discards any partial symbol. Capture resumes only after a new `start`.
- R10: `sym_valid` is low after reset and every assertion of it lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_rx_n | input | 1 | Asynchronous receiver line, active low, idle high |
| enable | input | 1 | Engine enable level |
| start | input | 1 | One-cycle strobe that arms capture |
| freq_mhz_m1 | input | FREQ_W (7) | Clock frequency in MHz minus one |
| max_width | input | DUR_W (16) | Stream-end limit on low+high, in units |
| sym_valid | output | 1 | One-cycle strobe for a completed symbol |
| sym_data | output | 2*DUR_W (32) | {high duration, low duration} |
| sym_end | output | 1 | High phase of this symbol ends the stream |
| timeout_evt | output | 1 | One-cycle stream-end timeout event |

## Verification
The bench sets the exact stream-end limit on both a long high phase and a saturated low phase. A design that compares the limit against the wrong count, or lets a counter wrap, would report a sum other than the limit or a low field far below all-ones. Short glitches are placed both in the idle line and in the middle of a low phase: a missing filter would start phantom symbols or split a pulse in two. The bench also drops the enable during a pulse and switches to a different clock-frequency setting. A partial symbol that leaked out, or a prescaler that ignored its field, would show up as an extra symbol or as durations off by a factor of two.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ARMED = 2'd1,
    ST_LOW   = 2'd2,
    ST_HIGH  = 2'd3
  } cap_state_e;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int FREQ_W  = 7,
  parameter int UNIT_US = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [FREQ_W-1:0] freq_m1,
  output logic              us_tick,
  output logic              unit_tick
);
  localparam int UW = (UNIT_US > 1) ? $clog2(UNIT_US) : 1;
  localparam logic [UW-1:0] US_LAST = UW'(UNIT_US - 1);

  logic [FREQ_W-1:0] cyc_q, cyc_d;
  logic [UW-1:0]     us_q, us_d;

  assign us_tick   = run && (cyc_q >= freq_m1);
  assign unit_tick = us_tick && (us_q == US_LAST);

  always_comb begin
    cyc_d = cyc_q;
    us_d  = us_q;
    if (!run) begin
      cyc_d = '0;
      us_d  = '0;
    end else if (us_tick) begin
      cyc_d = '0;
      us_d  = (us_q == US_LAST) ? '0 : us_q + 1'b1;
    end else begin
      cyc_d = cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      us_q  <= '0;
    end else begin
      cyc_q <= cyc_d;
      us_q  <= us_d;
    end
  end

  // R1: with a divisor above one, microsecond ticks are never adjacent
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (us_tick && freq_m1 != '0) |=> (!us_tick || freq_m1 == '0));
endmodule

// File: rtl/ir_glitch_filter.sv
module ir_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int UNIT_US     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_async,
  input  logic us_tick,
  output logic level,
  output logic fall,
  output logic rise
);
  localparam int CW = $clog2(UNIT_US + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(UNIT_US - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   raw_s;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   level_q, level_d;
  logic                   fall_q, fall_d, rise_q, rise_d;

  // synchroniser chain, reset to the idle (high) level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_async};
  end
  assign raw_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    cnt_d   = cnt_q;
    level_d = level_q;
    fall_d  = 1'b0;
    rise_d  = 1'b0;
    if (raw_s == level_q) begin
      cnt_d = '0;
    end else if (us_tick) begin
      if (cnt_q == CNT_LAST) begin
        level_d = raw_s;
        cnt_d   = '0;
        fall_d  = !raw_s;
        rise_d  = raw_s;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b1;
      fall_q  <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      level_q <= level_d;
      fall_q  <= fall_d;
      rise_q  <= rise_d;
    end
  end

  assign level = level_q;
  assign fall  = fall_q;
  assign rise  = rise_q;

  // R6: the filtered level only moves on a microsecond tick
  assert_level_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> $past(us_tick));
  // R6: an edge pulse always agrees with the new filtered level
  assert_edge_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> !level_q);
endmodule

// File: rtl/ir_symbol_fsm.sv
module ir_symbol_fsm
  import ir_cap_pkg::*;
#(
  parameter int DUR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               start,
  input  logic               fall,
  input  logic               rise,
  input  logic               unit_tick,
  input  logic [DUR_W-1:0]   max_width,
  output logic               sym_valid,
  output logic [2*DUR_W-1:0] sym_data,
  output logic               sym_end,
  output logic               timeout_evt
);
  localparam logic [DUR_W-1:0] DUR_MAX = {DUR_W{1'b1}};

  cap_state_e         state_q, state_d;
  logic [DUR_W-1:0]   low_q, low_d, high_q, high_d;
  logic               valid_q, valid_d, end_q, end_d, to_q, to_d;
  logic [2*DUR_W-1:0] data_q, data_d;
  logic [DUR_W:0]     sum_w;
  logic               limit_hit;

  assign sum_w     = {1'b0, low_q} + {1'b0, high_q};
  assign limit_hit = (sum_w >= {1'b0, max_width});

  always_comb begin
    state_d = state_q;
    low_d   = low_q;
    high_d  = high_q;
    valid_d = 1'b0;
    end_d   = 1'b0;
    to_d    = 1'b0;
    data_d  = data_q;
    if (!enable) begin
      state_d = ST_OFF;
      low_d   = '0;
      high_d  = '0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (start) state_d = ST_ARMED;
        end
        ST_ARMED: begin
          if (fall) begin
            state_d = ST_LOW;
            low_d   = '0;
            high_d  = '0;
          end
        end
        ST_LOW: begin
          if (rise) begin
            state_d = ST_HIGH;
          end else if (unit_tick && low_q != DUR_MAX) begin
            low_d = low_q + 1'b1;
          end
        end
        ST_HIGH: begin
          if (limit_hit) begin
            valid_d = 1'b1;
            end_d   = 1'b1;
            to_d    = 1'b1;
            data_d  = {high_q, low_q};
            state_d = ST_ARMED;
          end else if (fall) begin
            valid_d = 1'b1;
            data_d  = {high_q, low_q};
            state_d = ST_LOW;
            low_d   = '0;
            high_d  = '0;
          end else if (unit_tick && high_q != DUR_MAX) begin
            high_d = high_q + 1'b1;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      low_q   <= '0;
      high_q  <= '0;
      valid_q <= 1'b0;
      end_q   <= 1'b0;
      to_q    <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      low_q   <= low_d;
      high_q  <= high_d;
      valid_q <= valid_d;
      end_q   <= end_d;
      to_q    <= to_d;
      data_q  <= data_d;
    end
  end

  assign sym_valid   = valid_q;
  assign sym_data    = data_q;
  assign sym_end     = end_q;
  assign timeout_evt = to_q;

  // R10: a symbol strobe never lasts two cycles
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R4: a timeout event comes with a stream-end symbol
  assert_timeout_with_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> (valid_q && end_q));
  // R4: a stream-end symbol has reached the limit
  assert_end_reaches_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && end_q) |-> (({1'b0, data_q[2*DUR_W-1:DUR_W]} + {1'b0, data_q[DUR_W-1:0]})
                             >= {1'b0, $past(max_width)}));
  // R7: a saturated low count stays saturated
  assert_low_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state_q == ST_LOW && !rise && low_q == DUR_MAX) |=> (low_q == DUR_MAX));
  // R9: no symbol follows a cycle with the engine disabled
  assert_off_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !valid_q);
endmodule

// File: rtl/ir_symbol_capture.sv
module ir_symbol_capture #(
  parameter int FREQ_W      = 7,
  parameter int DUR_W       = 16,
  parameter int UNIT_US     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ir_rx_n,
  input  logic               enable,
  input  logic               start,
  input  logic [FREQ_W-1:0]  freq_mhz_m1,
  input  logic [DUR_W-1:0]   max_width,
  output logic               sym_valid,
  output logic [2*DUR_W-1:0] sym_data,
  output logic               sym_end,
  output logic               timeout_evt
);
  logic us_tick, unit_tick;
  logic line_lvl, line_fall, line_rise;

  ir_tick_gen #(
    .FREQ_W (FREQ_W),
    .UNIT_US(UNIT_US)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (enable),
    .freq_m1  (freq_mhz_m1),
    .us_tick  (us_tick),
    .unit_tick(unit_tick)
  );

  ir_glitch_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .UNIT_US    (UNIT_US)
  ) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_async(ir_rx_n),
    .us_tick   (us_tick),
    .level     (line_lvl),
    .fall      (line_fall),
    .rise      (line_rise)
  );

  ir_symbol_fsm #(
    .DUR_W(DUR_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .start      (start),
    .fall       (line_fall),
    .rise       (line_rise),
    .unit_tick  (unit_tick),
    .max_width  (max_width),
    .sym_valid  (sym_valid),
    .sym_data   (sym_data),
    .sym_end    (sym_end),
    .timeout_evt(timeout_evt)
  );

  // R2: edges seen by the engine alternate with the filtered level
  assert_rise_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_rise |-> line_lvl);
endmodule

// File: tb/tb_ir_symbol_capture.sv
module tb_ir_symbol_capture;
  localparam int CLK_PERIOD = 10;
  localparam int FREQ_W  = 7;
  localparam int DUR_W   = 8;
  localparam int UNIT_US = 2;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               ir_rx_n;
  logic               enable;
  logic               start;
  logic [FREQ_W-1:0]  freq_mhz_m1;
  logic [DUR_W-1:0]   max_width;
  logic               sym_valid;
  logic [2*DUR_W-1:0] sym_data;
  logic               sym_end;
  logic               timeout_evt;

  int errors = 0;
  int checks = 0;
  int n_sym = 0;
  int n_to = 0;
  int n_wide = 0;
  logic [2*DUR_W-1:0] cap_data [64];
  logic               cap_end  [64];
  logic               prev_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_symbol_capture #(
    .FREQ_W(FREQ_W), .DUR_W(DUR_W), .UNIT_US(UNIT_US), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ir_rx_n(ir_rx_n), .enable(enable), .start(start),
    .freq_mhz_m1(freq_mhz_m1), .max_width(max_width), .sym_valid(sym_valid),
    .sym_data(sym_data), .sym_end(sym_end), .timeout_evt(timeout_evt)
  );

  always @(negedge clk) begin
    if (rst_n && sym_valid) begin
      if (n_sym < 64) begin
        cap_data[n_sym] = sym_data;
        cap_end[n_sym]  = sym_end;
      end
      n_sym++;
    end
    if (rst_n && timeout_evt) n_to++;
    if (rst_n && sym_valid && prev_valid) n_wide++;
    prev_valid = sym_valid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit near(input int a, input int e);
    return (a >= e - 1) && (a <= e + 1);
  endfunction

  function automatic int lo_of(input int i);
    return int'(cap_data[i][DUR_W-1:0]);
  endfunction
  function automatic int hi_of(input int i);
    return int'(cap_data[i][2*DUR_W-1:DUR_W]);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // hold the line at lvl for a number of duration units
  task automatic phase(input logic lvl, input int units);
    @(negedge clk);
    ir_rx_n = lvl;
    cyc(units * (int'(freq_mhz_m1) + 1) * UNIT_US - 1);
  endtask

  task automatic arm(input int maxw);
    @(negedge clk);
    max_width = DUR_W'(maxw);
    enable = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    check(sym_valid == 1'b0, "R10 valid low after reset", int'(sym_valid), 0);
    check(timeout_evt == 1'b0, "R10 timeout low after reset", int'(timeout_evt), 0);
  endtask

  task automatic t_not_armed;
    int base = n_sym;
    @(negedge clk); enable = 1'b1; max_width = 8'd20;
    phase(1'b0, 6); phase(1'b1, 6); phase(1'b0, 6); phase(1'b1, 30);
    check(n_sym == base, "R8 no symbols without start", n_sym - base, 0);
    @(negedge clk); enable = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    phase(1'b0, 6); phase(1'b1, 30);
    check(n_sym == base, "R8 start ignored while disabled", n_sym - base, 0);
  endtask

  task automatic t_basic;
    int base = n_sym;
    int to0 = n_to;
    arm(100);
    phase(1'b1, 5);
    phase(1'b0, 12); phase(1'b1, 7);
    phase(1'b0, 20); phase(1'b1, 9);
    phase(1'b0, 3);  phase(1'b1, 110);
    check(n_sym - base == 3, "R3 symbol count", n_sym - base, 3);
    check(near(lo_of(base), 12), "R2 low field sym0", lo_of(base), 12);
    check(near(hi_of(base), 7), "R2 high field sym0", hi_of(base), 7);
    check(cap_end[base] == 1'b0, "R3 sym0 not end", int'(cap_end[base]), 0);
    check(near(lo_of(base+1), 20), "R2 low field sym1", lo_of(base+1), 20);
    check(near(hi_of(base+1), 9), "R3 high field sym1", hi_of(base+1), 9);
    check(near(lo_of(base+2), 3), "R2 low field sym2", lo_of(base+2), 3);
    check(lo_of(base+2) + hi_of(base+2) == 100, "R4 end sum equals limit",
          lo_of(base+2) + hi_of(base+2), 100);
    check(cap_end[base+2] == 1'b1, "R4 end flag", int'(cap_end[base+2]), 1);
    check(n_to - to0 == 1, "R4 one timeout event", n_to - to0, 1);
  endtask

  task automatic t_timeout;
    int base = n_sym;
    int to0 = n_to;
    max_width = 8'd30;
    phase(1'b0, 10); phase(1'b1, 70);
    check(n_sym - base == 1, "R5 single symbol on long high", n_sym - base, 1);
    check(lo_of(base) + hi_of(base) == 30, "R4 sum equals limit",
          lo_of(base) + hi_of(base), 30);
    check(near(lo_of(base), 10), "R4 low before timeout", lo_of(base), 10);
    phase(1'b0, 4); phase(1'b1, 40);
    check(n_sym - base == 2, "R5 new stream after edge", n_sym - base, 2);
    check(near(lo_of(base+1), 4), "R5 new stream low", lo_of(base+1), 4);
    check(n_to - to0 == 2, "R4 timeout events", n_to - to0, 2);
  endtask

  task automatic t_glitch;
    int base = n_sym;
    max_width = 8'd30;
    @(negedge clk); ir_rx_n = 1'b0;
    cyc(2);
    @(negedge clk); ir_rx_n = 1'b1;
    phase(1'b1, 20);
    check(n_sym == base, "R6 idle glitch ignored", n_sym - base, 0);
    phase(1'b0, 4);
    @(negedge clk); ir_rx_n = 1'b1;
    @(negedge clk); ir_rx_n = 1'b0;
    phase(1'b0, 4);
    phase(1'b1, 40);
    check(n_sym - base == 1, "R6 one symbol across glitch", n_sym - base, 1);
    check(near(lo_of(base), 8), "R6 low not split", lo_of(base), 8);
  endtask

  task automatic t_sat;
    int base = n_sym;
    max_width = 8'd255;
    phase(1'b0, 300); phase(1'b1, 10);
    check(n_sym - base == 1, "R7 one symbol", n_sym - base, 1);
    check(lo_of(base) == 255, "R7 low saturated", lo_of(base), 255);
    check(hi_of(base) == 0, "R7 immediate end high", hi_of(base), 0);
  endtask

  task automatic t_disable;
    int base = n_sym;
    max_width = 8'd40;
    phase(1'b0, 6);
    @(negedge clk); enable = 1'b0;
    cyc(5);
    arm(40);
    phase(1'b0, 3); phase(1'b1, 10);
    check(n_sym == base, "R9 partial discarded", n_sym - base, 0);
    phase(1'b0, 5); phase(1'b1, 50);
    check(n_sym - base == 1, "R9 capture after restart", n_sym - base, 1);
    check(near(lo_of(base), 5), "R9 fresh low", lo_of(base), 5);
  endtask

  task automatic t_freq;
    int base = n_sym;
    @(negedge clk); enable = 1'b0; freq_mhz_m1 = 7'd3;
    arm(40);
    phase(1'b1, 3);
    phase(1'b0, 6); phase(1'b1, 45);
    check(n_sym - base == 1, "R1 symbol at slower tick", n_sym - base, 1);
    check(near(lo_of(base), 6), "R1 low scales with frequency", lo_of(base), 6);
    check(lo_of(base) + hi_of(base) == 40, "R1 end sum", lo_of(base) + hi_of(base), 40);
  endtask

  initial begin
    cyc(200000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ir_rx_n = 1'b1; enable = 1'b0; start = 1'b0;
    freq_mhz_m1 = 7'd1; max_width = 8'd100;
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_not_armed();
    t_basic();
    t_timeout();
    t_glitch();
    t_sat();
    t_disable();
    t_freq();
    check(n_wide == 0, "R10 strobe one cycle", n_wide, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule